// File: doc/BRIEF.md
# Register-Less Dual-Rail XOR Pipeline with Enable-Gated Stages

This block is a three-stage dual-rail pipeline that has no stage registers. Each stage is a row of self-holding threshold gates. All the gates in a stage share one enable. A completion detector watches the stage outputs. A single XNOR combines that completion with the acknowledge from the stage after it, and its output is the stage enable. Data moves through a four-phase handshake, so every valid word is followed by an all-NULL word. The producer sees an acknowledge that follows the first stage's completion. The consumer returns its own acknowledge to the last stage.

Each stage maps a word `x` of `W` dual-rail bits to `y[i] = x[i] XOR x[(i+1) mod W]`. The three passes are applied in order. The gate and completion state is modelled as level-sensitive storage that is evaluated on every clock edge. Each gate either sets, clears or holds in each evaluation step. The width must be at least 2.

Top module: `rl_pipe`

## Requirements
- R1: Each bit uses two rails `(t,f)`. `(0,0)` is NULL, `(0,1)` is logic 0 and `(1,0)` is logic 1. A word is valid when every bit is 0 or 1, and NULL when every bit is `(0,0)`.
- R2: Each valid word at the output equals the input word after `NSTAGE` (default 3) neighbour-XOR passes. One pass maps `x` to `y[i] = x[i] ^ x[(i+1) mod W]`.
- R3: No output bit ever has both rails high while the producer drives only legal codes.
- R4: Every input word produces exactly one output word, and the words leave in the order they entered. None is lost and none is duplicated.
- R5: While the consumer keeps `ack_in` low after a valid output word, `dout` keeps that word. This holds even when the producer follows with NULL and then another valid word.
- R6: A gate that holds 1 clears only when all of its inputs are 0. An output word therefore returns to NULL only after `ack_in` goes high and a NULL wavefront has arrived behind it.
- R7: `ack_out` goes to 1 once the first stage holds a complete valid word. It stays at 1 until that stage holds a complete NULL word. It changes at no other time.
- R8: While `rst_n` is low, every gate output and every completion signal is 0. So `dout` is NULL and `ack_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Evaluation clock for the gate and completion state |
| rst_n | input | 1 | Active-low asynchronous reset |
| din_t | input | W | True rails of the input word |
| din_f | input | W | False rails of the input word |
| ack_out | output | 1 | Acknowledge to the producer (first-stage completion) |
| dout_t | output | W | True rails of the output word |
| dout_f | output | W | False rails of the output word |
| ack_in | input | 1 | Acknowledge from the consumer |

## Verification
Random words test the XOR chain with ordinary data. Each is followed by NULL, and the consumer acknowledges after a random delay. Any slip in the rotation index or in the rail mapping of a gate then shows as a wrong word. Three directed words are also used. All zeros and all ones produce an all-zero result, which exercises only the false-rail set terms. An alternating word does the same for the true-rail terms, since its first pass gives all ones. A directed stall holds the consumer acknowledge low while a NULL and a second word enter behind the first word. This separates correct hold-on-disable behaviour from gates that clear early or are overwritten early. Counting the words and keeping them in order catches a lost or duplicated word, which a wrong enable polarity would cause.

// File: rtl/rlp_pkg.sv
package rlp_pkg;

    // one dual-rail bit: t = true rail, f = false rail
    typedef struct packed {
        logic t;
        logic f;
    } rail_t;

    // state held by one self-holding threshold gate
    typedef struct packed {
        logic q;
    } gate_st_t;

    // state held by one completion detector
    typedef struct packed {
        logic done;
    } cdet_st_t;

endpackage

// File: rtl/rlp_th_gate.sv
// Self-holding four-input threshold gate: sets on a&b | c&d, clears only
// when every input is zero, and changes only while en is high.
module rlp_th_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic a,
    input  logic b,
    input  logic c,
    input  logic d,
    output logic q
);
    import rlp_pkg::*;

    gate_st_t st_d, st_q;
    logic set_term;
    logic clr_term;

    always_comb begin
        set_term = (a & b) | (c & d);
        clr_term = ~(a | b | c | d);
        st_d     = st_q;
        if (en) begin
            if (set_term)      st_d.q = 1'b1;
            else if (clr_term) st_d.q = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.q;

    // R5: a disabled gate keeps its value whatever its inputs do
    assert_hold_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (q == $past(q)));

    // R6: a set gate never clears while any input is still high
    assert_no_early_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q && (a | b | c | d)) |=> q);

endmodule

// File: rtl/rlp_xor_cell.sv
// Dual-rail two-input XOR made of two threshold gates sharing one enable.
module rlp_xor_cell (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  rlp_pkg::rail_t x,
    input  rlp_pkg::rail_t y,
    output rlp_pkg::rail_t z
);
    logic z_t;
    logic z_f;

    // true rail: x=1,y=0 or x=0,y=1
    rlp_th_gate u_true (
        .clk(clk), .rst_n(rst_n), .en(en),
        .a(x.t), .b(y.f), .c(x.f), .d(y.t),
        .q(z_t)
    );

    // false rail: x=1,y=1 or x=0,y=0
    rlp_th_gate u_false (
        .clk(clk), .rst_n(rst_n), .en(en),
        .a(x.t), .b(y.t), .c(x.f), .d(y.f),
        .q(z_f)
    );

    assign z.t = z_t;
    assign z.f = z_f;

    // R3: the two rails of a result bit are never both high
    assert_one_rail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(z_t && z_f));

endmodule

// File: rtl/rlp_cdet.sv
// Completion detector: a C-element over the per-bit OR of the rails.
module rlp_cdet #(
    parameter int W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  rlp_pkg::rail_t [W-1:0] bits,
    output logic               done
);
    import rlp_pkg::*;

    cdet_st_t   st_d, st_q;
    logic [W-1:0] has_val;
    logic         all_val;
    logic         all_nul;

    always_comb begin
        for (int i = 0; i < W; i++) has_val[i] = bits[i].t | bits[i].f;
        all_val = &has_val;
        all_nul = ~|has_val;
        st_d    = st_q;
        if (all_val)      st_d.done = 1'b1;
        else if (all_nul) st_d.done = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.done;

    // R7: completion rises only after a whole valid word was present
    assert_rise_on_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(all_val));

    // R7: completion falls only after a whole NULL word was present
    assert_fall_on_null_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> $past(all_nul));

endmodule

// File: rtl/rlp_stage.sv
// One pipeline stage: neighbour-XOR row, completion detector, XNOR control.
module rlp_stage #(
    parameter int W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  rlp_pkg::rail_t [W-1:0] in_bits,
    input  logic                   ack_next,
    output rlp_pkg::rail_t [W-1:0] out_bits,
    output logic                   done
);
    import rlp_pkg::*;

    logic en;

    // enable is high while completion and downstream acknowledge agree
    assign en = ~(done ^ ack_next);

    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam int NB = (i + 1) % W;
        rlp_xor_cell u_cell (
            .clk(clk), .rst_n(rst_n), .en(en),
            .x(in_bits[i]), .y(in_bits[NB]),
            .z(out_bits[i])
        );
    end

    rlp_cdet #(.W(W)) u_cdet (
        .clk(clk), .rst_n(rst_n),
        .bits(out_bits),
        .done(done)
    );

endmodule

// File: rtl/rl_pipe.sv
// Register-less dual-rail pipeline of NSTAGE neighbour-XOR stages.
module rl_pipe #(
    parameter int W      = 8,
    parameter int NSTAGE = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din_t,
    input  logic [W-1:0] din_f,
    output logic         ack_out,
    output logic [W-1:0] dout_t,
    output logic [W-1:0] dout_f,
    input  logic         ack_in
);
    import rlp_pkg::*;

    localparam int LAST = NSTAGE - 1;

    rail_t [W-1:0] bus [0:NSTAGE];
    logic          stage_done [0:LAST];

    always_comb begin
        for (int i = 0; i < W; i++) begin
            bus[0][i].t = din_t[i];
            bus[0][i].f = din_f[i];
        end
    end

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        logic ack_nx;
        if (s == LAST) begin : g_tail
            assign ack_nx = ack_in;
        end else begin : g_mid
            assign ack_nx = stage_done[s+1];
        end
        rlp_stage #(.W(W)) u_stage (
            .clk(clk), .rst_n(rst_n),
            .in_bits(bus[s]),
            .ack_next(ack_nx),
            .out_bits(bus[s+1]),
            .done(stage_done[s])
        );
    end

    always_comb begin
        for (int i = 0; i < W; i++) begin
            dout_t[i] = bus[NSTAGE][i].t;
            dout_f[i] = bus[NSTAGE][i].f;
        end
    end

    assign ack_out = stage_done[0];

    // R3: no output bit carries both rails high
    assert_out_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_t & dout_f) == '0);

    // R5: with the consumer not acknowledging, a valid output word is held
    assert_out_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (((dout_t ^ dout_f) == {W{1'b1}}) && !ack_in) |=>
        ($stable(dout_t) && $stable(dout_f)));

endmodule

// File: tb/sim_rl_pipe.sv
module sim_rl_pipe;
    localparam int W      = 8;
    localparam int NSTAGE = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] din_t = '0;
    logic [W-1:0] din_f = '0;
    logic         ack_out;
    logic [W-1:0] dout_t;
    logic [W-1:0] dout_f;
    logic         ack_in = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int n_sent = 0;
    int n_recv = 0;
    int both_hi = 0;
    logic stall = 1'b0;
    logic done_run = 1'b0;
    logic [W-1:0] expq [$];

    always #5 clk = ~clk;

    rl_pipe #(.W(W), .NSTAGE(NSTAGE)) u0 (
        .clk(clk), .rst_n(rst_n),
        .din_t(din_t), .din_f(din_f), .ack_out(ack_out),
        .dout_t(dout_t), .dout_f(dout_f), .ack_in(ack_in)
    );

    function automatic logic [W-1:0] pass1(input logic [W-1:0] x);
        logic [W-1:0] y;
        for (int i = 0; i < W; i++) y[i] = x[i] ^ x[(i + 1) % W];
        return y;
    endfunction

    function automatic logic [W-1:0] model(input logic [W-1:0] x);
        logic [W-1:0] y = x;
        for (int s = 0; s < NSTAGE; s++) y = pass1(y);
        return y;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit out_valid();
        return (dout_t ^ dout_f) == {W{1'b1}};
    endfunction

    function automatic bit out_null();
        return (dout_t | dout_f) == '0;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // rail monitor for R3
    always @(negedge clk) if (rst_n && ((dout_t & dout_f) != '0)) both_hi++;

    // watchdog
    initial begin
        repeat (150000) @(negedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    // consumer: check every word once, acknowledge after a random delay
    initial begin
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            while (!out_valid()) @(negedge clk);
            n_recv++;
            if (expq.size() == 0) begin
                chk(1'b0, "R4 extra word", dout_t, 0);
            end else begin
                logic [W-1:0] e;
                e = expq.pop_front();
                chk(dout_t == model(e), "R2 word value", dout_t, model(e));
            end
            while (stall) @(negedge clk);
            repeat ($urandom_range(0, 4)) @(negedge clk);
            ack_in = 1'b1;
            while (!out_null()) @(negedge clk);
            repeat ($urandom_range(0, 4)) @(negedge clk);
            ack_in = 1'b0;
        end
    end

    task automatic send_data(input logic [W-1:0] w);
        din_t = w;
        din_f = ~w;
        expq.push_back(w);
        n_sent++;
        while (!ack_out) @(negedge clk);
    endtask

    task automatic send_null();
        din_t = '0;
        din_f = '0;
        while (ack_out) @(negedge clk);
        repeat ($urandom_range(0, 3)) @(negedge clk);
    endtask

    initial begin
        logic [W-1:0] w1;
        logic [W-1:0] w2;
        int stuck;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(out_null(), "R8 dout NULL in reset", {dout_t, dout_f}, 0);
        chk(ack_out == 1'b0, "R8 ack_out low in reset", ack_out, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(out_null() && !ack_out, "R8 idle after reset", {ack_out, dout_t, dout_f}, 0);

        // directed corners: R1 encoding, all-zero and all-one words
        send_data('0);           send_null();
        send_data({W{1'b1}});    send_null();
        send_data({(W/2){2'b10}}); send_null();

        // R5/R6/R7: consumer stall with NULL and a second word behind
        while (expq.size() != 0 || !out_null()) @(negedge clk);
        stall = 1'b1;
        w1 = 8'h3c;
        w2 = 8'ha5;
        send_data(w1);
        send_null();
        send_data(w2);
        stuck = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (!ack_out) stuck++;
        end
        chk(dout_t == model(w1) && out_valid(), "R5 output held during stall", dout_t, model(w1));
        chk(stuck == 0, "R7 ack_out steady while word held", stuck, 0);
        chk(ack_in == 1'b0 && !out_null(), "R6 no NULL without ack_in", {ack_in, dout_t}, {1'b0, model(w1)});
        stall = 1'b0;
        send_null();

        // random traffic
        for (int n = 0; n < 150; n++) begin
            send_data(W'($urandom()));
            send_null();
        end

        while (expq.size() != 0 || !out_null() || ack_in) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(n_recv == n_sent, "R4 words out equal words in", n_recv, n_sent);
        chk(expq.size() == 0, "R4 nothing left pending", expq.size(), 0);
        chk(both_hi == 0, "R3 no bit with both rails high", both_hi, 0);
        chk(out_null() && !ack_out, "R6 pipeline drained to NULL", {ack_out, dout_t, dout_f}, 0);
        done_run = 1'b1;
        summary();
    end
endmodule